// File: doc/BRIEF.md
# Memory Attribute Remap Unit

This block turns the three attribute bits of a page-table descriptor (TEX bit 0, C and B) into the memory attributes that the rest of the memory system uses: a memory type, a shareable flag, and inner and outer cacheability. It works in two stages. Stage one uses a primary remap register to choose the memory type and the shareable flag. Stage two applies only to regions that stage one classifies as Normal; it reads the inner and outer cacheability from a second register, the normal-memory remap register. When the remap-enable input is low, neither register is consulted and a fixed default decode is used. The non-secure attribute bit of the descriptor is never remapped.

Each of the two registers exists twice: once for the secure world and once for the non-secure world. A system-register port reads and writes the copy that matches the security state of the access. Accesses from user mode are rejected with an undefined-instruction indication. A secure privileged write is also rejected while the security write-lock input is high. The lookup path is purely combinational from the current register contents. It uses the copy that matches the security state of the translation being looked up.

Top module: `mem_attr_remap`

## Requirements
- R1: After reset, all four register copies read as zero (primary and normal, secure and non-secure).
- R2: A privileged access with `cfg_sel`=0 reaches the primary register and one with `cfg_sel`=1 reaches the normal-memory register. The copy used is secure when `cfg_secure`=1 and non-secure when `cfg_secure`=0. A write takes effect at the next clock edge, and the other three copies are left untouched.
- R3: Any access with `cfg_priv`=0 raises `cfg_undef` in the same cycle and changes no register, in either security state.
- R4: A write with `cfg_secure`=1, `cfg_priv`=1 and `sec_wr_lock`=1 raises `cfg_undef` and is dropped. Under the lock, secure privileged reads and non-secure privileged writes still work.
- R5: `cfg_rdata` is zero whenever there is no access (`cfg_valid`=0), when the access is a write, or when `cfg_undef` is high.
- R6: With `lk_remap_en`=1, the index i = {tex0,c,b} selects the type field at primary bits [2i+1:2i]. The field is decoded as 00 Strongly-ordered, 01 Device and 10 Normal; the reserved value 11 is treated as Normal. `lk_mtype` reports 00, 01 or 10 respectively.
- R7: With `lk_remap_en`=1, `lk_shareable` equals primary bit [16+i] for Device and Normal regions. It is always 1 for Strongly-ordered regions.
- R8: With `lk_remap_en`=1 and a Normal region, the inner cacheability is normal-register bits [2i+1:2i] and the outer cacheability is bits [17+2i:16+2i]. The encoding is 00 non-cacheable, 01 write-back write-allocate, 10 write-through and 11 write-back no-allocate. Device and Strongly-ordered regions report 00 for both.
- R9: The lookup uses the secure register copies when `lk_secure`=1 and the non-secure copies when `lk_secure`=0.
- R10: With `lk_remap_en`=0, the registers are ignored and a fixed decode of {tex0,c,b} applies:
  - 000: Strongly-ordered, shareable.
  - 001: Device, shareable.
  - 010: Normal, write-through inner and outer.
  - 011: Normal, write-back no-allocate inner and outer.
  - 100, 101 and 110: Normal, non-cacheable.
  - 111: Normal, write-back write-allocate.
  - All Normal encodings in this default decode are non-shareable.
- R11: `lk_ns_out` always equals `lk_ns_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Register access request this cycle |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_sel | input | 1 | 0 = primary register, 1 = normal-memory register |
| cfg_secure | input | 1 | Security state of the access |
| cfg_priv | input | 1 | 1 = privileged, 0 = user |
| cfg_wdata | input | 32 | Write data |
| sec_wr_lock | input | 1 | Blocks secure privileged writes when high |
| cfg_rdata | output | 32 | Read data (combinational) |
| cfg_undef | output | 1 | Undefined-instruction indication for the current access |
| lk_secure | input | 1 | Security state of the translation being looked up |
| lk_remap_en | input | 1 | Remap enable |
| lk_tex0 | input | 1 | Descriptor TEX bit 0 |
| lk_c | input | 1 | Descriptor C bit |
| lk_b | input | 1 | Descriptor B bit |
| lk_ns_in | input | 1 | Descriptor non-secure bit |
| lk_mtype | output | 2 | Memory type: 00 Strongly-ordered, 01 Device, 10 Normal |
| lk_shareable | output | 1 | Shareable attribute |
| lk_inner | output | 2 | Inner cacheability |
| lk_outer | output | 2 | Outer cacheability |
| lk_ns_out | output | 1 | Non-secure bit, passed through unchanged |

## Verification
The bench goes after the following corner cases:

- **Reserved type code 11.** A decoder that forgets to fold it into Normal would report a fourth type, or zero the cacheability.
- **Stale cacheability on non-Normal regions.** A Device or Strongly-ordered region whose normal-memory register fields are non-zero would leak those fields if stage two were not gated by stage one.
- **Locked secure writes.** A lock that also blocked non-secure writes or secure reads would show up as false undefined indications. A lock that ignored the write would show up as a changed secure copy on readback.
- **Bank confusion.** Random accesses in both security states, with lookups in the opposite state, expose a swapped bank, a user write that slips through, or a lookup that ignores the remap-enable input.

// File: rtl/mar_pkg.sv
package mar_pkg;
    localparam int MAR_DW    = 32;
    localparam int MAR_NIDX  = 8;
    localparam int MAR_IW    = $clog2(MAR_NIDX);
    localparam int MAR_HALF  = MAR_DW / 2;

    typedef enum logic [1:0] {
        MT_STRONG = 2'b00,
        MT_DEVICE = 2'b01,
        MT_NORMAL = 2'b10,
        MT_RSVD   = 2'b11
    } mar_mtype_e;

    typedef enum logic [1:0] {
        CA_NC   = 2'b00,
        CA_WBWA = 2'b01,
        CA_WT   = 2'b10,
        CA_WBNA = 2'b11
    } mar_cache_e;

    typedef struct packed {
        logic [MAR_DW-1:0] prim;
        logic [MAR_DW-1:0] norm;
    } mar_bank_t;
endpackage

// File: rtl/mar_cfg_regs.sv
module mar_cfg_regs
    import mar_pkg::*;
#(
    parameter int DW = MAR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_valid,
    input  logic          cfg_write,
    input  logic          cfg_sel,
    input  logic          cfg_secure,
    input  logic          cfg_priv,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          sec_wr_lock,
    output logic [DW-1:0] cfg_rdata,
    output logic          cfg_undef,
    output logic [DW-1:0] prim_s,
    output logic [DW-1:0] norm_s,
    output logic [DW-1:0] prim_ns,
    output logic [DW-1:0] norm_ns
);
    localparam int NBANK = 2;

    typedef struct packed {
        logic [NBANK-1:0][DW-1:0] prim;
        logic [NBANK-1:0][DW-1:0] norm;
    } regs_t;

    regs_t st_d, st_q;
    logic  trap_user, trap_lock, wr_ok;
    logic  bank_idx;

    always_comb begin
        bank_idx  = cfg_secure;
        trap_user = cfg_valid && !cfg_priv;
        trap_lock = cfg_valid && cfg_priv && cfg_write && cfg_secure && sec_wr_lock;
        cfg_undef = trap_user || trap_lock;
        wr_ok     = cfg_valid && cfg_write && !cfg_undef;

        st_d = st_q;
        if (wr_ok) begin
            if (cfg_sel) st_d.norm[bank_idx] = cfg_wdata;
            else         st_d.prim[bank_idx] = cfg_wdata;
        end

        cfg_rdata = '0;
        if (cfg_valid && !cfg_write && !cfg_undef) begin
            cfg_rdata = cfg_sel ? st_q.norm[bank_idx] : st_q.prim[bank_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prim_s  = st_q.prim[1];
    assign norm_s  = st_q.norm[1];
    assign prim_ns = st_q.prim[0];
    assign norm_ns = st_q.norm[0];
endmodule

// File: rtl/mar_stage1.sv
module mar_stage1
    import mar_pkg::*;
#(
    parameter int DW   = MAR_DW,
    parameter int NIDX = MAR_NIDX
) (
    input  logic [DW-1:0]           prim,
    input  logic                    remap_en,
    input  logic [$clog2(NIDX)-1:0] idx,
    output mar_mtype_e              mtype,
    output logic                    shareable
);
    localparam int IW   = $clog2(NIDX);
    localparam int HALF = DW / 2;

    logic [NIDX-1:0][1:0] type_fld;
    logic [NIDX-1:0]      shr_fld;

    for (genvar g = 0; g < NIDX; g++) begin : g_fld
        assign type_fld[g] = prim[2*g +: 2];
        assign shr_fld[g]  = prim[HALF + g];
    end

    always_comb begin
        mtype     = MT_NORMAL;
        shareable = 1'b0;
        if (remap_en) begin
            unique case (type_fld[idx])
                2'b00:   mtype = MT_STRONG;
                2'b01:   mtype = MT_DEVICE;
                default: mtype = MT_NORMAL;
            endcase
            shareable = (mtype == MT_STRONG) ? 1'b1 : shr_fld[idx];
        end else begin
            unique case (idx)
                IW'(0): begin mtype = MT_STRONG; shareable = 1'b1; end
                IW'(1): begin mtype = MT_DEVICE; shareable = 1'b1; end
                default: begin mtype = MT_NORMAL; shareable = 1'b0; end
            endcase
        end
    end
endmodule

// File: rtl/mar_stage2.sv
module mar_stage2
    import mar_pkg::*;
#(
    parameter int DW   = MAR_DW,
    parameter int NIDX = MAR_NIDX
) (
    input  logic [DW-1:0]           norm,
    input  logic                    remap_en,
    input  logic [$clog2(NIDX)-1:0] idx,
    input  mar_mtype_e              mtype,
    output mar_cache_e              inner,
    output mar_cache_e              outer
);
    localparam int IW   = $clog2(NIDX);
    localparam int HALF = DW / 2;

    logic [NIDX-1:0][1:0] in_fld;
    logic [NIDX-1:0][1:0] out_fld;

    for (genvar g = 0; g < NIDX; g++) begin : g_fld
        assign in_fld[g]  = norm[2*g +: 2];
        assign out_fld[g] = norm[HALF + 2*g +: 2];
    end

    always_comb begin
        inner = CA_NC;
        outer = CA_NC;
        if (mtype == MT_NORMAL) begin
            if (remap_en) begin
                inner = mar_cache_e'(in_fld[idx]);
                outer = mar_cache_e'(out_fld[idx]);
            end else begin
                unique case (idx)
                    IW'(2): begin inner = CA_WT;   outer = CA_WT;   end
                    IW'(3): begin inner = CA_WBNA; outer = CA_WBNA; end
                    IW'(7): begin inner = CA_WBWA; outer = CA_WBWA; end
                    default: begin inner = CA_NC;  outer = CA_NC;   end
                endcase
            end
        end
    end
endmodule

// File: rtl/mem_attr_remap.sv
module mem_attr_remap
    import mar_pkg::*;
#(
    parameter int DW   = MAR_DW,
    parameter int NIDX = MAR_NIDX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_valid,
    input  logic          cfg_write,
    input  logic          cfg_sel,
    input  logic          cfg_secure,
    input  logic          cfg_priv,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          sec_wr_lock,
    output logic [DW-1:0] cfg_rdata,
    output logic          cfg_undef,
    input  logic          lk_secure,
    input  logic          lk_remap_en,
    input  logic          lk_tex0,
    input  logic          lk_c,
    input  logic          lk_b,
    input  logic          lk_ns_in,
    output logic [1:0]    lk_mtype,
    output logic          lk_shareable,
    output logic [1:0]    lk_inner,
    output logic [1:0]    lk_outer,
    output logic          lk_ns_out
);
    localparam int IW = $clog2(NIDX);

    logic [DW-1:0] prim_s, norm_s, prim_ns, norm_ns;
    logic [DW-1:0] prim_sel, norm_sel;
    logic [IW-1:0] lk_idx;
    mar_mtype_e    mtype;
    mar_cache_e    inner, outer;

    mar_cfg_regs #(.DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_valid   (cfg_valid),
        .cfg_write   (cfg_write),
        .cfg_sel     (cfg_sel),
        .cfg_secure  (cfg_secure),
        .cfg_priv    (cfg_priv),
        .cfg_wdata   (cfg_wdata),
        .sec_wr_lock (sec_wr_lock),
        .cfg_rdata   (cfg_rdata),
        .cfg_undef   (cfg_undef),
        .prim_s      (prim_s),
        .norm_s      (norm_s),
        .prim_ns     (prim_ns),
        .norm_ns     (norm_ns)
    );

    always_comb begin
        lk_idx   = IW'({lk_tex0, lk_c, lk_b});
        prim_sel = lk_secure ? prim_s : prim_ns;
        norm_sel = lk_secure ? norm_s : norm_ns;
    end

    mar_stage1 #(.DW(DW), .NIDX(NIDX)) u_st1 (
        .prim      (prim_sel),
        .remap_en  (lk_remap_en),
        .idx       (lk_idx),
        .mtype     (mtype),
        .shareable (lk_shareable)
    );

    mar_stage2 #(.DW(DW), .NIDX(NIDX)) u_st2 (
        .norm     (norm_sel),
        .remap_en (lk_remap_en),
        .idx      (lk_idx),
        .mtype    (mtype),
        .inner    (inner),
        .outer    (outer)
    );

    assign lk_mtype  = mtype;
    assign lk_inner  = inner;
    assign lk_outer  = outer;
    assign lk_ns_out = lk_ns_in;
endmodule

// File: rtl/mem_attr_remap_chk.sv
module mem_attr_remap_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_valid,
    input logic          cfg_write,
    input logic          cfg_secure,
    input logic          cfg_priv,
    input logic          sec_wr_lock,
    input logic          cfg_undef,
    input logic [DW-1:0] cfg_rdata,
    input logic          lk_remap_en,
    input logic [1:0]    lk_mtype,
    input logic          lk_shareable,
    input logic [1:0]    lk_inner,
    input logic [1:0]    lk_outer,
    input logic [DW-1:0] prim_s,
    input logic [DW-1:0] norm_s,
    input logic [DW-1:0] prim_ns,
    input logic [DW-1:0] norm_ns
);
    a_r3_user_traps: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_priv |-> cfg_undef);

    a_r3_user_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_priv |=> $stable(prim_s) && $stable(norm_s)
                                   && $stable(prim_ns) && $stable(norm_ns));

    a_r4_lock_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_write && cfg_secure && cfg_priv && sec_wr_lock
        |=> $stable(prim_s) && $stable(norm_s));

    a_r2_ns_write_spares_secure: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_write && !cfg_secure
        |=> $stable(prim_s) && $stable(norm_s));

    a_r5_no_data_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_undef |-> cfg_rdata == '0);

    a_r7_strong_shareable: assert property (@(posedge clk) disable iff (!rst_n)
        lk_mtype == 2'b00 |-> lk_shareable);

    a_r8_non_normal_uncached: assert property (@(posedge clk) disable iff (!rst_n)
        lk_mtype != 2'b10 |-> lk_inner == 2'b00 && lk_outer == 2'b00);

    a_r6_no_reserved_type: assert property (@(posedge clk) disable iff (!rst_n)
        lk_remap_en |-> lk_mtype != 2'b11);
endmodule

bind mem_attr_remap mem_attr_remap_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_valid    (cfg_valid),
    .cfg_write    (cfg_write),
    .cfg_secure   (cfg_secure),
    .cfg_priv     (cfg_priv),
    .sec_wr_lock  (sec_wr_lock),
    .cfg_undef    (cfg_undef),
    .cfg_rdata    (cfg_rdata),
    .lk_remap_en  (lk_remap_en),
    .lk_mtype     (lk_mtype),
    .lk_shareable (lk_shareable),
    .lk_inner     (lk_inner),
    .lk_outer     (lk_outer),
    .prim_s       (prim_s),
    .norm_s       (norm_s),
    .prim_ns      (prim_ns),
    .norm_ns      (norm_ns)
);

// File: tb/mem_attr_remap_tb_top.sv
module mem_attr_remap_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 4000;
    localparam int WDOG       = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 0, cfg_write = 0, cfg_sel = 0, cfg_secure = 0, cfg_priv = 0;
    logic [31:0] cfg_wdata = '0;
    logic        sec_wr_lock = 0;
    logic [31:0] cfg_rdata;
    logic        cfg_undef;
    logic        lk_secure = 0, lk_remap_en = 0, lk_tex0 = 0, lk_c = 0, lk_b = 0, lk_ns_in = 0;
    logic [1:0]  lk_mtype, lk_inner, lk_outer;
    logic        lk_shareable, lk_ns_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_prim [2];
    logic [31:0] m_norm [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_attr_remap dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_sel(cfg_sel),
        .cfg_secure(cfg_secure), .cfg_priv(cfg_priv), .cfg_wdata(cfg_wdata),
        .sec_wr_lock(sec_wr_lock), .cfg_rdata(cfg_rdata), .cfg_undef(cfg_undef),
        .lk_secure(lk_secure), .lk_remap_en(lk_remap_en), .lk_tex0(lk_tex0),
        .lk_c(lk_c), .lk_b(lk_b), .lk_ns_in(lk_ns_in),
        .lk_mtype(lk_mtype), .lk_shareable(lk_shareable), .lk_inner(lk_inner),
        .lk_outer(lk_outer), .lk_ns_out(lk_ns_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // expected lookup: {mtype[1:0], share, inner[1:0], outer[1:0]}
    function automatic logic [6:0] exp_lookup(input logic sec, input logic en, input logic [2:0] i);
        logic [1:0] t, ci, co;
        logic       sh;
        if (en) begin
            t  = m_prim[sec][2*i +: 2];
            if (t == 2'b11) t = 2'b10;
            sh = (t == 2'b00) ? 1'b1 : m_prim[sec][16 + i];
            ci = (t == 2'b10) ? m_norm[sec][2*i +: 2] : 2'b00;
            co = (t == 2'b10) ? m_norm[sec][16 + 2*i +: 2] : 2'b00;
        end else begin
            case (i)
                3'd0: begin t = 2'b00; sh = 1; ci = 2'b00; co = 2'b00; end
                3'd1: begin t = 2'b01; sh = 1; ci = 2'b00; co = 2'b00; end
                3'd2: begin t = 2'b10; sh = 0; ci = 2'b10; co = 2'b10; end
                3'd3: begin t = 2'b10; sh = 0; ci = 2'b11; co = 2'b11; end
                3'd7: begin t = 2'b10; sh = 0; ci = 2'b01; co = 2'b01; end
                default: begin t = 2'b10; sh = 0; ci = 2'b00; co = 2'b00; end
            endcase
        end
        return {t, sh, ci, co};
    endfunction

    task automatic check_lookup(input string req);
        logic [6:0] e;
        e = exp_lookup(lk_secure, lk_remap_en, {lk_tex0, lk_c, lk_b});
        check(req, 32'({lk_mtype, lk_shareable, lk_inner, lk_outer}), 32'(e));
        check("R11", 32'(lk_ns_out), 32'(lk_ns_in));
    endtask

    // one access cycle: drive at negedge, check comb outputs, update model at edge
    task automatic access(input logic v, input logic w, input logic s, input logic sec,
                          input logic pr, input logic lk, input logic [31:0] d);
        logic exp_undef;
        logic [31:0] exp_rd;
        @(negedge clk);
        cfg_valid = v; cfg_write = w; cfg_sel = s; cfg_secure = sec;
        cfg_priv = pr; sec_wr_lock = lk; cfg_wdata = d;
        #1;
        exp_undef = v && (!pr || (w && sec && lk));
        exp_rd = '0;
        if (v && !w && !exp_undef) exp_rd = s ? m_norm[sec] : m_prim[sec];
        check(!pr ? "R3" : (w && sec && lk) ? "R4" : "R2", 32'(cfg_undef), 32'(exp_undef));
        check((v && !w && !exp_undef) ? "R2" : "R5", cfg_rdata, exp_rd);
        check_lookup(lk_remap_en ? "R8" : "R10");
        @(posedge clk);
        if (v && w && !exp_undef) begin
            if (s) m_norm[sec] = d;
            else   m_prim[sec] = d;
        end
    endtask

    task automatic set_lk(input logic sec, input logic en, input logic [2:0] i, input logic ns);
        lk_secure = sec; lk_remap_en = en; {lk_tex0, lk_c, lk_b} = i; lk_ns_in = ns;
    endtask

    initial begin : wdog
        repeat (WDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h1a2b3c4d));
        for (int b = 0; b < 2; b++) begin m_prim[b] = '0; m_norm[b] = '0; end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state of all four copies
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cfg_valid = 1; cfg_write = 0; cfg_priv = 1; cfg_sel = k[0]; cfg_secure = k[1];
            #1 check("R1", cfg_rdata, 32'h0);
        end

        // R10: default decode, registers ignored
        access(1, 1, 0, 1, 1, 0, 32'hFFFF_FFFF);
        access(1, 1, 1, 1, 1, 0, 32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); cfg_valid = 0;
            set_lk(1, 0, 3'(i), 1'(i));
            #1 check_lookup("R10");
        end

        // R6 R7 R8: reserved type 11, device and strongly-ordered with cache bits set
        access(1, 1, 0, 1, 1, 0, 32'h00AA_E4E4);
        access(1, 1, 1, 0, 1, 0, 32'h0000_0000);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            set_lk(1, 1, 3'(i), 0);
            #1 check_lookup("R6");
            check("R8", 32'({lk_inner, lk_outer}),
                  (lk_mtype == 2'b10) ? 32'h0000_000F : 32'h0);
        end

        // R9: non-secure copy differs
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            set_lk(0, 1, 3'(i), 1);
            #1 check_lookup("R9");
        end

        // R4: lock blocks secure write, spares reads and non-secure writes
        access(1, 1, 0, 1, 1, 1, 32'h1234_5678);
        access(1, 0, 0, 1, 1, 1, 32'h0);
        access(1, 1, 0, 0, 1, 1, 32'h5555_AAAA);
        access(1, 0, 0, 0, 1, 1, 32'h0);

        // R3: user accesses in both states
        access(1, 1, 1, 0, 0, 0, 32'hDEAD_BEEF);
        access(1, 0, 1, 1, 0, 0, 32'h0);
        access(1, 0, 1, 0, 1, 0, 32'h0);

        // random mix
        for (int n = 0; n < NRAND; n++) begin
            logic [31:0] r;
            r = $urandom;
            set_lk(r[10], r[11] | r[12], r[15:13], r[16]);
            access(r[0] | r[1], r[2], r[3], r[4], r[5] | r[6] | r[7], r[8] & r[9], $urandom);
        end

        @(negedge clk); cfg_valid = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule